// File: doc/BRIEF.md
# Parallel DAC Bus Write Sequencer

This block is the host-side master for a 12-bit parallel converter bus. It generates active-low chip select, active-low write enable, a register-select line, a 12-bit data bus and an active-low load strobe. Every write cycle meets the converter's minimum interface timing: chip-select setup, data and register-select setup, hold after the write-enable rising edge, write-enable high time between pulses, and the delay and width of the load strobe. Each interval is given in nanoseconds. It is turned into a whole number of clock cycles by rounding up against a clock-period parameter.

Words arrive through a ready/valid port. Each word is tagged either as a converter code or as a control word. One word can wait in a single staging slot while the previous write finishes its load strobe. A mode input selects a waveform source in place of the host. When that mode starts, the source first writes a control word that selects fast settling and the 2.048 V internal reference. After that it writes a 12-bit sawtooth code on every tick of a free-running timer. A second mode input keeps the load strobe low all the time, so that the converter updates directly from its holding latch.

Top module: `dacbus_seq`

## Requirements
- R1: While reset is held and just after it is released (with `ld_hold_low` = 0), `bus_cs_n`, `bus_we_n` and `bus_ld_n` are 1, `bus_data` and `bus_sel` are 0, and `req_ready` is 1.
- R2: Chip select is low for at least ceil(CS_NS/clock period) cycles before write enable falls. The default is 2 cycles at 8 ns.
- R3: Write enable stays low for at least the larger of the rounded-up data setup and register-select setup counts. The default is 3 cycles. `bus_data` and `bus_sel` hold one value from the fall of chip select until its rise.
- R4: After write enable rises, chip select, data and register select stay unchanged for at least ceil(HOLD_NS/period) cycles. The default is 1 cycle.
- R5: Between two write-enable low pulses, write enable is high for at least ceil(WEH_NS/period) cycles. The default is 3 cycles.
- R6: With `ld_hold_low` = 0, a code write (`bus_sel` = 0) is followed by exactly one load-strobe low pulse. The pulse falls at least ceil(LDD_NS/period) cycles after write enable rises (default 1) and lasts at least ceil(LDW_NS/period) cycles (default 3). A control write (`bus_sel` = 1) produces no pulse.
- R7: With `ld_hold_low` = 1, `bus_ld_n` stays 0 throughout every write.
- R8: `req_ready` is 0 in the cycle after a word is accepted, and stays 0 while a write is in chip-select setup, write-enable low or hold.
- R9: When `ramp_en` rises while the bus is idle, the first write is a control write (`bus_sel` = 1) of 0x011. In that word, bit 0 = 1 selects fast mode and bits 4:3 = 2'b10 select the 2.048 V internal reference.
- R10: After the control write, ramp mode writes codes (`bus_sel` = 0) 0x000, 0x001, … in order, one per timer tick. The code wraps from 0xFFF to 0x000.
- R11: A timer tick that arrives while a write is in progress is kept pending and not dropped. N ramp codes take no more than N×TICK_CYCLES cycles plus a fixed latency.
- R12: While `ramp_en` is 1, host requests are ignored: `req_ready` is 0 and no host word reaches the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host word valid |
| req_ready | output | 1 | Host word accepted when high together with valid |
| req_ctrl | input | 1 | 1 = control word, 0 = converter code |
| req_word | input | 12 | Host word |
| ramp_en | input | 1 | Selects the built-in sawtooth source |
| ld_hold_low | input | 1 | 1 = load strobe held low permanently |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write enable, active low; the converter latches on its rise |
| bus_sel | output | 1 | Register select: 1 = control register, 0 = holding latch |
| bus_data | output | 12 | Data bus |
| bus_ld_n | output | 1 | Load strobe, active low |

## Verification
The bench keeps the default 8000 ps clock period and nanosecond limits. The interval counts therefore come out as 2, 3, 1, 3, 1 and 3 cycles, and a bus monitor compares each measured interval against counts it computes itself. TICK_CYCLES is reduced to 12. One write with its load pulse takes 11 cycles, so ticks regularly land while a write is still in progress. At this setting more than 4096 ramp codes fit in about 49,000 cycles, which brings the 0xFFF to 0x000 wrap and the no-drop bound within reach.

// File: rtl/dacbus_pkg.sv
package dacbus_pkg;

  localparam int WORD_W = 12;

  // control word for ramp start: bit0 fast settling, bits4:3 = 2'b10 -> 2.048 V internal reference
  localparam logic [WORD_W-1:0] RAMP_CFG_WORD = 12'h011;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CSU,
    PH_WEL,
    PH_HOLD,
    PH_LDWAIT,
    PH_LDLOW,
    PH_REST
  } phase_t;

  typedef struct packed {
    logic              ctrl;
    logic [WORD_W-1:0] word;
  } xfer_t;

  // round a nanosecond limit up to whole clock cycles, never below one
  function automatic int ns_to_cyc(input int ns, input int period_ps);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycles still to wait when part of an interval is already covered
  function automatic int rem_cyc(input int need, input int done);
    return (need > done) ? need - done : 0;
  endfunction

  function automatic logic [WORD_W-1:0] ramp_next(input logic [WORD_W-1:0] c);
    return c + 1'b1;
  endfunction

endpackage

// File: rtl/dacbus_ramp.sv
module dacbus_ramp
  import dacbus_pkg::*;
#(
  parameter int TICK_CYCLES = 1000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  output logic  out_valid,
  input  logic  out_ready,
  output xfer_t out_x
);

  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic              en_q;
  logic              cfg_pend;
  logic              tick_pend;
  logic [TW-1:0]     tcnt;
  logic [WORD_W-1:0] code;

  // named events
  logic en_rise_w, tick_w, acc_w, acc_code_w;
  assign en_rise_w  = en && !en_q;
  assign tick_w     = en && (tcnt == TW'(TICK_CYCLES - 1));
  assign acc_w      = out_valid && out_ready;
  assign acc_code_w = acc_w && !cfg_pend;

  assign out_valid = en && (cfg_pend || tick_pend);
  assign out_x     = cfg_pend ? xfer_t'{ctrl: 1'b1, word: RAMP_CFG_WORD}
                              : xfer_t'{ctrl: 1'b0, word: code};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      cfg_pend  <= 1'b0;
      tick_pend <= 1'b0;
      tcnt      <= '0;
      code      <= '0;
    end else begin
      en_q <= en;
      if (!en) begin
        cfg_pend  <= 1'b0;
        tick_pend <= 1'b0;
        tcnt      <= '0;
        code      <= '0;
      end else begin
        if (en_rise_w)  cfg_pend <= 1'b1;
        else if (acc_w) cfg_pend <= 1'b0;
        tcnt <= tick_w ? '0 : tcnt + 1'b1;
        if (tick_w)          tick_pend <= 1'b1;
        else if (acc_code_w) tick_pend <= 1'b0;
        if (acc_code_w) code <= ramp_next(code);
      end
    end
  end

  // a pending tick survives until a code write takes it
  assert_tick_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick_pend && !acc_code_w) |=> (tick_pend || !en));

endmodule

// File: rtl/dacbus_phy.sv
module dacbus_phy
  import dacbus_pkg::*;
#(
  parameter int CS_CYC     = 2,
  parameter int LOW_CYC    = 3,
  parameter int HOLD_CYC   = 1,
  parameter int WEH_CYC    = 3,
  parameter int LD_PRE_CYC = 0,
  parameter int LD_CYC     = 3,
  parameter int REST_NEED  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  xfer_t             in_x,
  input  logic              ld_hold_low,
  output logic              cs_n,
  output logic              we_n,
  output logic              sel,
  output logic [WORD_W-1:0] data,
  output logic              ld_n
);

  localparam int MAXC  = max2(max2(max2(CS_CYC, LOW_CYC), max2(HOLD_CYC, WEH_CYC)),
                              max2(max2(LD_PRE_CYC, LD_CYC), REST_NEED));
  localparam int CNT_W = $clog2(MAXC + 1);

  phase_t           ph, ph_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [CNT_W-1:0] hi_cnt;
  xfer_t            stage, cur;
  logic             stage_full;

  // named events
  logic busy_w, accept_w, start_w, pulse_w, cnt_done_w;
  assign busy_w     = (ph == PH_CSU) || (ph == PH_WEL) || (ph == PH_HOLD);
  assign in_ready   = !stage_full && !busy_w;
  assign accept_w   = in_valid && in_ready;
  assign start_w    = (ph == PH_IDLE) && stage_full;
  assign pulse_w    = !cur.ctrl && !ld_hold_low;
  assign cnt_done_w = (cnt == '0);

  always_comb begin
    ph_nx  = ph;
    cnt_nx = cnt_done_w ? cnt : cnt - 1'b1;
    unique case (ph)
      PH_IDLE:
        if (stage_full) begin
          ph_nx  = PH_CSU;
          cnt_nx = CNT_W'(CS_CYC - 1);
        end
      PH_CSU:
        if (cnt_done_w) begin
          ph_nx  = PH_WEL;
          cnt_nx = CNT_W'(LOW_CYC - 1);
        end
      PH_WEL:
        if (cnt_done_w) begin
          ph_nx  = PH_HOLD;
          cnt_nx = CNT_W'(HOLD_CYC - 1);
        end
      PH_HOLD:
        if (cnt_done_w) begin
          if (!pulse_w) begin
            ph_nx = PH_REST;
          end else if (LD_PRE_CYC > 0) begin
            ph_nx  = PH_LDWAIT;
            cnt_nx = CNT_W'(LD_PRE_CYC - 1);
          end else begin
            ph_nx  = PH_LDLOW;
            cnt_nx = CNT_W'(LD_CYC - 1);
          end
        end
      PH_LDWAIT:
        if (cnt_done_w) begin
          ph_nx  = PH_LDLOW;
          cnt_nx = CNT_W'(LD_CYC - 1);
        end
      PH_LDLOW:
        if (cnt_done_w) ph_nx = PH_REST;
      PH_REST:
        if (hi_cnt >= CNT_W'(REST_NEED)) ph_nx = PH_IDLE;
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      cnt        <= '0;
      hi_cnt     <= CNT_W'(REST_NEED);
      stage      <= '0;
      cur        <= '0;
      stage_full <= 1'b0;
    end else begin
      ph  <= ph_nx;
      cnt <= cnt_nx;
      if (ph == PH_WEL)                        hi_cnt <= '0;
      else if (hi_cnt < CNT_W'(REST_NEED))     hi_cnt <= hi_cnt + 1'b1;
      if (start_w) begin
        cur        <= stage;
        stage_full <= 1'b0;
      end else if (accept_w) begin
        stage      <= in_x;
        stage_full <= 1'b1;
      end
    end
  end

  assign cs_n = !busy_w;
  assign we_n = (ph != PH_WEL);
  assign sel  = cur.ctrl;
  assign data = cur.word;
  assign ld_n = !(ld_hold_low || (ph == PH_LDLOW));

  // ---------------- interval monitors for assertions ----------------
  localparam int MW = $clog2(MAXC + 2);
  logic [MW-1:0] cs_run, we_run, hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_run <= '0;
      we_run <= '0;
      hi_run <= MW'(WEH_CYC);
    end else begin
      if (cs_n)                       cs_run <= '0;
      else if (cs_run < MW'(MAXC))    cs_run <= cs_run + 1'b1;
      if (we_n)                       we_run <= '0;
      else if (we_run < MW'(MAXC))    we_run <= we_run + 1'b1;
      if (!we_n)                      hi_run <= '0;
      else if (hi_run < MW'(WEH_CYC)) hi_run <= hi_run + 1'b1;
    end
  end

  assert_cs_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> (cs_run >= MW'(CS_CYC)));

  assert_we_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_run >= MW'(LOW_CYC)));

  assert_bus_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable({sel, data}));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> !cs_n);

  assert_we_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> (hi_run >= MW'(WEH_CYC)));

  assert_ld_code_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ld_n) && !ld_hold_low) |-> (!sel && cs_n && we_n));

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !in_ready);

endmodule

// File: rtl/dacbus_seq.sv
module dacbus_seq
  import dacbus_pkg::*;
#(
  parameter int CLK_PS      = 8000,
  parameter int CS_NS       = 15,
  parameter int DSET_NS     = 10,
  parameter int SSET_NS     = 20,
  parameter int HOLD_NS     = 5,
  parameter int WEH_NS      = 20,
  parameter int LDD_NS      = 5,
  parameter int LDW_NS      = 23,
  parameter int TICK_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ctrl,
  input  logic [WORD_W-1:0] req_word,
  input  logic              ramp_en,
  input  logic              ld_hold_low,
  output logic              bus_cs_n,
  output logic              bus_we_n,
  output logic              bus_sel,
  output logic [WORD_W-1:0] bus_data,
  output logic              bus_ld_n
);

  localparam int CS_CYC     = ns_to_cyc(CS_NS, CLK_PS);
  localparam int LOW_CYC    = max2(ns_to_cyc(DSET_NS, CLK_PS), ns_to_cyc(SSET_NS, CLK_PS));
  localparam int HOLD_CYC   = ns_to_cyc(HOLD_NS, CLK_PS);
  localparam int WEH_CYC    = ns_to_cyc(WEH_NS, CLK_PS);
  localparam int LD_PRE_CYC = rem_cyc(ns_to_cyc(LDD_NS, CLK_PS), HOLD_CYC);
  localparam int LD_CYC     = ns_to_cyc(LDW_NS, CLK_PS);
  localparam int REST_NEED  = rem_cyc(WEH_CYC, CS_CYC);

  logic  rmp_valid, rmp_ready, phy_valid, phy_ready;
  xfer_t rmp_x, phy_x;

  dacbus_ramp #(
    .TICK_CYCLES(TICK_CYCLES)
  ) ramp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ramp_en),
    .out_valid(rmp_valid),
    .out_ready(rmp_ready),
    .out_x    (rmp_x)
  );

  assign phy_valid = ramp_en ? rmp_valid : req_valid;
  assign phy_x     = ramp_en ? rmp_x : xfer_t'{ctrl: req_ctrl, word: req_word};
  assign rmp_ready = ramp_en && phy_ready;
  assign req_ready = !ramp_en && phy_ready;

  dacbus_phy #(
    .CS_CYC    (CS_CYC),
    .LOW_CYC   (LOW_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .WEH_CYC   (WEH_CYC),
    .LD_PRE_CYC(LD_PRE_CYC),
    .LD_CYC    (LD_CYC),
    .REST_NEED (REST_NEED)
  ) phy_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (phy_valid),
    .in_ready   (phy_ready),
    .in_x       (phy_x),
    .ld_hold_low(ld_hold_low),
    .cs_n       (bus_cs_n),
    .we_n       (bus_we_n),
    .sel        (bus_sel),
    .data       (bus_data),
    .ld_n       (bus_ld_n)
  );

endmodule

// File: tb/dacbus_seq_tb.sv
module dacbus_seq_tb_top;

  localparam int TICK = 12;
  // expected cycle counts at 8 ns: ceil(15/8), max(ceil(10/8),ceil(20/8)), ceil(5/8), ceil(20/8), ceil(5/8), ceil(23/8)
  localparam int E_CS = 2, E_LOW = 3, E_HOLD = 1, E_WEH = 3, E_LDD = 1, E_LDW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ctrl = 1'b0, ramp_en = 1'b0, ld_hold_low = 1'b0;
  logic [11:0] req_word = '0;
  logic        req_ready, bus_cs_n, bus_we_n, bus_sel, bus_ld_n;
  logic [11:0] bus_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dacbus_seq #(.TICK_CYCLES(TICK)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctrl(req_ctrl), .req_word(req_word), .ramp_en(ramp_en),
    .ld_hold_low(ld_hold_low), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
    .bus_sel(bus_sel), .bus_data(bus_data), .bus_ld_n(bus_ld_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- bus monitor, sampled at falling clock edges ----------------
  logic [12:0] log_mem [0:8191];
  int log_n = 0, ld_pulses = 0;
  int cs_run = 0, we_low = 0, we_high = E_WEH, since_rise = 0, hold_cnt = 0, ld_low = 0;
  logic p_cs = 1, p_we = 1, p_ld = 1;
  logic [12:0] at_cs_fall = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!bus_cs_n && p_cs) at_cs_fall = {bus_sel, bus_data};
      if (!bus_we_n && p_we) begin
        chk(cs_run >= E_CS, "R2 cs setup", cs_run, E_CS);
        chk(we_high >= E_WEH, "R5 we high gap", we_high, E_WEH);
      end
      if (bus_we_n && !p_we) begin
        chk(we_low >= E_LOW, "R3 we low width", we_low, E_LOW);
        chk({bus_sel, bus_data} == at_cs_fall, "R3 data stable", {bus_sel, bus_data}, at_cs_fall);
        chk(!bus_cs_n, "R4 cs held after we rise", bus_cs_n, 0);
        if (log_n < 8192) log_mem[log_n] = {bus_sel, bus_data};
        log_n++;
        since_rise = 0;
        hold_cnt = 0;
      end
      if (bus_cs_n && !p_cs) begin
        chk(hold_cnt >= E_HOLD, "R4 hold", hold_cnt, E_HOLD);
        chk({bus_sel, bus_data} == at_cs_fall, "R4 data held", {bus_sel, bus_data}, at_cs_fall);
      end
      if (!bus_ld_n && p_ld && !ld_hold_low) begin
        ld_pulses++;
        chk(since_rise >= E_LDD, "R6 load delay", since_rise, E_LDD);
        chk(log_n > 0 && log_mem[(log_n - 1) % 8192][12] == 1'b0, "R6 load after code write", 1, 0);
      end
      if (bus_ld_n && !p_ld) chk(ld_low >= E_LDW, "R6 load width", ld_low, E_LDW);
      cs_run     = bus_cs_n ? 0 : cs_run + 1;
      we_low     = bus_we_n ? 0 : we_low + 1;
      we_high    = bus_we_n ? we_high + 1 : 0;
      ld_low     = bus_ld_n ? 0 : ld_low + 1;
      since_rise = since_rise + 1;
      if (bus_we_n && !bus_cs_n) hold_cnt = hold_cnt + 1;
    end
    p_cs = bus_cs_n; p_we = bus_we_n; p_ld = bus_ld_n;
  end

  // ---------------- helpers ----------------
  task automatic send(input logic c, input logic [11:0] w);
    @(negedge clk);
    req_valid = 1'b1; req_ctrl = c; req_word = w;
    #1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8 ready low after accept", req_ready, 0);
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(bus_cs_n && bus_we_n && bus_ld_n, "R1 strobes high in reset", {bus_cs_n, bus_we_n, bus_ld_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    chk({bus_sel, bus_data} == 13'h0, "R1 bus zero", {bus_sel, bus_data}, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
  endtask

  task automatic t_code_write();
    int n0 = log_n, p0 = ld_pulses;
    send(1'b0, 12'hA5C);
    settle();
    chk(log_n == n0 + 1 && log_mem[n0] == {1'b0, 12'hA5C}, "R3 code write content", log_mem[n0], {1'b0, 12'hA5C});
    chk(ld_pulses == p0 + 1, "R6 one pulse per code write", ld_pulses - p0, 1);
  endtask

  task automatic t_ctrl_write();
    int n0 = log_n, p0 = ld_pulses;
    send(1'b1, 12'h011);
    settle();
    chk(log_mem[n0] == {1'b1, 12'h011}, "R6 control write content", log_mem[n0], {1'b1, 12'h011});
    chk(ld_pulses == p0, "R6 no pulse on control write", ld_pulses - p0, 0);
  endtask

  task automatic t_ready_busy();
    int seen_ready = 0;
    send(1'b0, 12'h123);
    // the write is now in setup/low/hold: ready must stay low until hold ends
    while (bus_cs_n) @(negedge clk);
    while (!bus_cs_n) begin
      if (req_ready) seen_ready++;
      @(negedge clk);
    end
    chk(seen_ready == 0, "R8 ready low during write", seen_ready, 0);
    settle();
  endtask

  task automatic t_back_to_back();
    int n0 = log_n;
    send(1'b0, 12'h001);
    send(1'b1, 12'hFFE);
    send(1'b0, 12'h7FF);
    settle();
    chk(log_mem[n0] == 13'h0001 && log_mem[n0+1] == {1'b1, 12'hFFE} && log_mem[n0+2] == 13'h07FF,
        "R5 back-to-back order", log_mem[n0+2], 13'h07FF);
  endtask

  task automatic t_transparent();
    int highs = 0, n0 = log_n;
    @(negedge clk);
    ld_hold_low = 1'b1;
    fork
      send(1'b0, 12'h3C3);
      repeat (25) begin
        @(negedge clk);
        if (bus_ld_n) highs++;
      end
    join
    chk(highs == 0, "R7 load held low", highs, 0);
    chk(log_mem[n0] == 13'h03C3, "R7 write in transparent mode", log_mem[n0], 13'h03C3);
    ld_hold_low = 1'b0;
    settle();
  endtask

  task automatic t_ramp();
    int base, start, bad = 0, first_bad = 0, host_ready = 0;
    @(negedge clk);
    base = log_n;
    start = cyc;
    ramp_en = 1'b1;
    req_valid = 1'b1; req_ctrl = 1'b0; req_word = 12'hBAD;
    while (log_n < base + 4099 && cyc - start < 60000) begin
      @(negedge clk);
      if (req_ready) host_ready++;
    end
    chk(cyc - start <= 4098 * TICK + 40, "R11 no tick dropped", cyc - start, 4098 * TICK + 40);
    req_valid = 1'b0;
    @(negedge clk);
    ramp_en = 1'b0;
    settle();
    chk(host_ready == 0, "R12 host blocked in ramp", host_ready, 0);
    chk(log_mem[base] == {1'b1, 12'h011}, "R9 ramp config first", log_mem[base], {1'b1, 12'h011});
    for (int i = 0; i < 4098; i++) begin
      if (log_mem[base + 1 + i] != {1'b0, 12'(i)}) begin
        if (bad == 0) first_bad = i;
        bad++;
      end
    end
    chk(bad == 0, "R10 ramp sequence", first_bad, 0);
    chk(log_mem[base + 4097] == 13'h0000 && log_mem[base + 4096] == 13'h0FFF,
        "R10 wrap to zero", log_mem[base + 4097], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_code_write();
    t_ctrl_write();
    t_ready_busy();
    t_back_to_back();
    t_transparent();
    t_ramp();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule